// File: doc/BRIEF.md
# I2C Master-Receive Burst Sequencer

This block runs the data phase of an I2C master read. A single write to its control port sets a byte count and a flag that chooses whether the final byte is refused. The burst starts at once. The sequencer generates SCL and shifts in each byte MSB first, sampling SDA while SCL is released. It then drives the acknowledge slot itself and stores the byte in a first-word-fall-through receive FIFO. Software or a neighbouring block drains the FIFO through a pop port.

The acknowledge rule depends on the count. Every byte is acknowledged except the final byte of a burst whose flag is set, and that byte gets a NAK. A read longer than the FIFO can therefore be split into several bursts. The earlier bursts acknowledge all their bytes, and only the final burst releases SDA on its last byte. When the count runs out, a sticky completion status is raised, and it can be routed to an interrupt through its own enable. The block never overruns its FIFO: if the FIFO is full when a byte is about to be stored, SCL is held low until a pop frees a slot.

Top module: `rx_burst_seq`

## Requirements
- R1: A control write (`ctl_we`) while idle, with a nonzero count in `ctl_wdata[6:0]`, makes `busy` high on the next cycle with SCL driven low (`scl_oe`=1). `busy` stays high until the last byte is stored.
- R2: Each byte is assembled MSB first from `sda_i`, sampled in the last cycle of each SCL-high half. Bytes appear at `rd_data` in the order they were received.
- R3: In the ninth (acknowledge) clock of each byte, the block drives SDA low (`sda_oe`=1) as ACK. When `ctl_wdata[7]` was 1 at start, the final byte of the burst gets a NAK instead (`sda_oe`=0). When that bit was 0, every byte including the last is acknowledged.
- R4: The edge that stores the final byte also drops `busy` and sets `done_sts`. `done_sts` stays set until `sts_clr`. `irq` is high exactly when `done_sts` and `ie_done` are both 1.
- R5: A start with count 0 sets `done_sts` on the next cycle without raising `busy` and without driving SCL.
- R6: A control write while `busy` is high is ignored. The running burst keeps its count and its NAK choice, and no second burst follows.
- R7: The FIFO holds 64 bytes. `rx_empty` is 1 when it holds none. A `pop` shows the next byte on `rd_data` one cycle later. A `pop` while the FIFO is empty has no effect.
- R8: If the FIFO is full when a byte's acknowledge slot would begin its high half, SCL is held low until a pop frees a slot. No byte is ever lost.
- R9: A count above 64 in `ctl_wdata[6:0]` is treated as 64.
- R10: After reset the block is idle: `busy`=0, `done_sts`=0, `scl_oe`=0, `sda_oe`=0, `rx_empty`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control write strobe; starts a burst when idle |
| ctl_wdata | input | 8 | [6:0] byte count, [7] refuse the final byte |
| ie_done | input | 1 | Interrupt enable for the completion status |
| sts_clr | input | 1 | Clears the completion status |
| pop | input | 1 | Removes the head byte of the FIFO |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low (ACK) |
| busy | output | 1 | Burst in progress |
| done_sts | output | 1 | Sticky completion status |
| irq | output | 1 | Completion interrupt |
| rd_data | output | 8 | Head byte of the FIFO |
| rx_empty | output | 1 | FIFO empty |

## Verification
The assertions assume the target holds SDA stable while SCL is released. They also assume that pops come only from a drain port, that only the sequencer pushes into the FIFO, and that reset is applied before the first control write. The bench's target model changes `sda_i` only a few nanoseconds after the sequencer pulls SCL low, and keeps it until SCL is pulled low again. Its pops and control writes are made at the falling clock edge. A pop on an empty FIFO is used only to show that it is ignored.

// File: rtl/rxseq_pkg.sv
package rxseq_pkg;

  localparam int CTL_W       = 8;
  localparam int CTL_NAK_BIT = 7;
  localparam int CNT_W       = 7;
  localparam int BYTE_W      = 8;
  localparam int ACK_SLOT    = 8;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] raw,
                                                    input int unsigned     depth);
    if (int'(raw) > int'(depth)) return CNT_W'(depth);
    return raw;
  endfunction

  function automatic logic master_acks(input logic [CNT_W-1:0] left,
                                       input logic             refuse_last);
    return !(refuse_last && (left == CNT_W'(1)));
  endfunction

endpackage

// File: rtl/rxseq_fifo.sv
module rxseq_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic          do_pop, do_push;

  assign empty   = (level == '0);
  assign full    = (level == LW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  p_pop_empty_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);

endmodule

// File: rtl/rxseq_bit_timer.sv
module rxseq_bit_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic last
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [TW-1:0] cnt;

  assign last = run && (cnt == TW'(HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (last && hold) cnt <= cnt;
    else if (last)         cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  p_idle_count_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

endmodule

// File: rtl/rxseq_ctrl.sv
module rxseq_ctrl
  import rxseq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              sda_i,
  input  logic              fifo_full,
  input  logic              half_last,
  output logic              run,
  output logic              stall,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              push,
  output logic [BYTE_W-1:0] push_data,
  output logic              done_evt
);
  phase_e           phase;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] left;
  logic             refuse_last;
  logic [BYTE_W-1:0] shreg;
  logic             accept;
  logic [CNT_W-1:0] eff_cnt;
  logic             in_ack;

  assign accept    = ctl_we && (phase == PH_IDLE);
  assign eff_cnt   = clamp_count(ctl_wdata[CNT_W-1:0], DEPTH);
  assign in_ack    = (bit_idx == 4'(ACK_SLOT));
  assign run       = (phase != PH_IDLE);
  assign busy      = run;
  assign stall     = (phase == PH_LOW) && in_ack && fifo_full;
  assign scl_oe    = (phase == PH_LOW);
  assign sda_oe    = run && in_ack && master_acks(left, refuse_last);
  assign push      = (phase == PH_HIGH) && half_last && in_ack;
  assign push_data = shreg;
  assign done_evt  = (push && (left == CNT_W'(1))) || (accept && (eff_cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      bit_idx     <= '0;
      left        <= '0;
      refuse_last <= 1'b0;
      shreg       <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (accept && (eff_cnt != '0)) begin
            phase       <= PH_LOW;
            left        <= eff_cnt;
            refuse_last <= ctl_wdata[CTL_NAK_BIT];
            bit_idx     <= '0;
          end
        end
        PH_LOW: begin
          if (half_last && !stall) phase <= PH_HIGH;
        end
        PH_HIGH: begin
          if (half_last) begin
            if (!in_ack) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_i};
              bit_idx <= bit_idx + 1'b1;
              phase   <= PH_LOW;
            end else if (left == CNT_W'(1)) begin
              bit_idx <= '0;
              phase   <= PH_IDLE;
            end else begin
              left    <= left - 1'b1;
              bit_idx <= '0;
              phase   <= PH_LOW;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_start_drives_scl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (eff_cnt != '0)) |=> (busy && scl_oe));

  p_zero_stays_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (eff_cnt == '0)) |=> !busy);

  p_sda_moves_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe);

  p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && busy) |=> $stable(refuse_last));

  p_stall_holds_scl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> scl_oe);

endmodule

// File: rtl/rx_burst_seq.sv
module rx_burst_seq
  import rxseq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              ie_done,
  input  logic              sts_clr,
  input  logic              pop,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done_sts,
  output logic              irq,
  output logic [BYTE_W-1:0] rd_data,
  output logic              rx_empty
);
  logic              run, stall, half_last;
  logic              push, done_evt, fifo_full;
  logic [BYTE_W-1:0] push_data;

  rxseq_bit_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .hold (stall),
    .last (half_last)
  );

  rxseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .sda_i    (sda_i),
    .fifo_full(fifo_full),
    .half_last(half_last),
    .run      (run),
    .stall    (stall),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (busy),
    .push     (push),
    .push_data(push_data),
    .done_evt (done_evt)
  );

  rxseq_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(push_data),
    .pop      (pop),
    .head     (rd_data),
    .empty    (rx_empty),
    .full     (fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done_sts <= 1'b0;
    else if (done_evt) done_sts <= 1'b1;
    else if (sts_clr)  done_sts <= 1'b0;
  end

  assign irq = done_sts && ie_done;

  p_done_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> done_sts);

  p_busy_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_sts);

endmodule

// File: tb/rx_burst_seq_tb.sv
`timescale 1ns/1ps
module rx_burst_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic       ie_done = 1'b0;
  logic       sts_clr = 1'b0;
  logic       pop = 1'b0;
  logic       sda_i = 1'b1;
  logic       scl_oe, sda_oe, busy, done_sts, irq, rx_empty;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] slv_data [128];
  logic       ack_log  [128];
  int         slv_byte = 0;
  int         slv_pos  = 0;
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  rx_burst_seq u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ie_done(ie_done), .sts_clr(sts_clr), .pop(pop), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .done_sts(done_sts),
    .irq(irq), .rd_data(rd_data), .rx_empty(rx_empty)
  );

  // target model: new bit after SCL is pulled low, ACK observed once SCL is released
  initial begin
    forever begin
      @(posedge scl_oe);
      #2;
      if (slv_pos < 8) sda_i = slv_data[slv_byte][7 - slv_pos];
      else             sda_i = 1'b1;
      @(negedge scl_oe);
      #2;
      if (slv_pos == 8) begin
        ack_log[slv_byte] = sda_oe;
        exp_q.push_back(slv_data[slv_byte]);
        slv_byte = slv_byte + 1;
        slv_pos  = 0;
      end else begin
        slv_pos = slv_pos + 1;
      end
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input int n, input int seed);
    slv_byte = 0;
    slv_pos  = 0;
    for (int k = 0; k < 128; k++) begin
      slv_data[k] = 8'(seed + k * 53) ^ 8'hA5;
      ack_log[k]  = 1'bx;
    end
    if (n > 128) $display("note: prep size too large");
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic clr_sts();
    @(negedge clk); sts_clr = 1'b1;
    @(negedge clk); sts_clr = 1'b0;
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] e;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
    @(negedge clk);
    check(rd_data === e && !rx_empty, req, int'(rd_data), int'(e));
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
  endtask

  task automatic t_reset();
    check(!busy && !done_sts && !scl_oe && !sda_oe && rx_empty, "R10 reset state",
          {busy, done_sts, scl_oe, sda_oe, rx_empty}, 1);
  endtask

  task automatic t_nak_last();
    prep(3, 7);
    wr_ctl(8'h83);
    check(busy && scl_oe, "R1 busy and SCL low after start", {busy, scl_oe}, 3);
    wait_idle();
    check(done_sts, "R4 done after last byte", done_sts, 1);
    check(ack_log[0] === 1'b1 && ack_log[1] === 1'b1, "R3 ACK on early bytes",
          {ack_log[0], ack_log[1]}, 3);
    check(ack_log[2] === 1'b0, "R3 NAK on final byte", ack_log[2], 0);
    for (int k = 0; k < 3; k++) pop_chk("R2 byte order and value");
    @(negedge clk);
    check(rx_empty, "R7 empty after draining", rx_empty, 1);
    clr_sts();
    check(!done_sts, "R4 status cleared", done_sts, 0);
  endtask

  task automatic t_all_ack();
    prep(4, 91);
    wr_ctl(8'h04);
    wait_idle();
    check(ack_log[3] === 1'b1 && ack_log[0] === 1'b1, "R3 last byte ACKed when flag clear",
          ack_log[3], 1);
    for (int k = 0; k < 4; k++) pop_chk("R2 chunk data");
    clr_sts();
  endtask

  task automatic t_zero();
    int scl_seen;
    prep(0, 3);
    scl_seen = 0;
    wr_ctl(8'h80);
    check(done_sts && !busy, "R5 zero count completes at once", {done_sts, busy}, 2);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scl_oe || busy) scl_seen++;
    end
    check(scl_seen == 0 && slv_byte == 0, "R5 bus untouched", scl_seen, 0);
    clr_sts();
  endtask

  task automatic t_ignore();
    prep(3, 200);
    wr_ctl(8'h03);
    repeat (20) @(negedge clk);
    wr_ctl(8'h85);
    wait_idle();
    repeat (60) @(negedge clk);
    check(!busy && slv_byte == 3, "R6 write during burst ignored (byte count)", slv_byte, 3);
    check(ack_log[2] === 1'b1, "R6 NAK choice kept from start", ack_log[2], 1);
    for (int k = 0; k < 3; k++) pop_chk("R6 data unaffected");
    clr_sts();
  endtask

  task automatic t_irq();
    prep(1, 17);
    ie_done = 1'b0;
    wr_ctl(8'h81);
    wait_idle();
    @(negedge clk);
    check(done_sts && !irq, "R4 irq masked", irq, 0);
    ie_done = 1'b1;
    @(negedge clk);
    check(irq, "R4 irq enabled", irq, 1);
    clr_sts();
    check(!irq, "R4 irq cleared with status", irq, 0);
    ie_done = 1'b0;
    pop_chk("R2 single byte");
  endtask

  task automatic t_pop_empty();
    @(negedge clk); pop = 1'b1;
    repeat (2) @(negedge clk);
    pop = 1'b0;
    check(rx_empty, "R7 pop on empty keeps empty", rx_empty, 1);
    prep(1, 66);
    wr_ctl(8'h81);
    wait_idle();
    pop_chk("R7 first byte after empty pops");
    @(negedge clk);
    check(rx_empty, "R7 empty again", rx_empty, 1);
    clr_sts();
  endtask

  task automatic t_clamp();
    prep(100, 129);
    wr_ctl(8'hE4);
    wait_idle();
    repeat (60) @(negedge clk);
    check(slv_byte == 64, "R9 count clamped to 64", slv_byte, 64);
    check(ack_log[62] === 1'b1 && ack_log[63] === 1'b0, "R9 NAK on clamped last byte",
          {ack_log[62], ack_log[63]}, 2);
    check(!rx_empty && done_sts, "R7 FIFO holds 64 bytes", rx_empty, 0);
    clr_sts();
  endtask

  task automatic t_stall();
    prep(2, 240);
    wr_ctl(8'h82);
    repeat (300) @(negedge clk);
    check(busy && scl_oe && !done_sts, "R8 SCL held low while FIFO full",
          {busy, scl_oe, done_sts}, 6);
    check(slv_byte == 0, "R8 first byte not yet stored", slv_byte, 0);
    for (int k = 0; k < 64; k++) pop_chk("R8 old bytes intact");
    wait_idle();
    check(done_sts && slv_byte == 2, "R8 burst resumes after pop", slv_byte, 2);
    check(ack_log[1] === 1'b0, "R3 NAK after stall", ack_log[1], 0);
    for (int k = 0; k < 2; k++) pop_chk("R8 stalled burst data");
    @(negedge clk);
    check(rx_empty, "R7 drained", rx_empty, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_nak_last();
    t_all_ack();
    t_zero();
    t_ignore();
    t_irq();
    t_pop_empty();
    t_clamp();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule